// File: doc/BRIEF.md
# Central Domain Stop Arbiter

This block is one of a pair of peer arbiters in the central interconnect. It gathers fatal-error stop requests from the node concentrators and from the crossbar ports of its own half. It passes each locally received request to the peer arbiter over notify wires, and it accepts the peer's notifications as a third source. It settles on one stop type, either a domain stop or a reset stop. It then issues a single stop demand that names the node in error and carries the set of crossbar ports to halt.

After the demand, the arbiter waits until every domain resource has acknowledged. Acknowledges may arrive in any order and need not be held. It then raises an interrupt to the system controller and keeps it raised until software clears the stop. Requests that arrive while a stop is in progress are dropped.

The per-port stop decision accounts for split nodes. The reachability matrix and the split mask are both programmed by software. A status output keeps the first requester, its source and the stop type for readout.

Top module: `stop_arbiter`

## Requirements
- R1: After reset, irq, dmd_valid and ntfy_out are 0 and stat_src is 0 (none).
- R2: When idle, the first request is chosen by priority: the lowest-indexed node_req bit wins; with no node request, the lowest-indexed xbar_err bit wins; with neither, a peer notification wins. The choice is recorded in stat_node and in stat_src, coded 1 node, 2 crossbar, 3 peer.
- R3: A winning node or crossbar request pulses ntfy_out for exactly the one cycle after the capture edge, with ntfy_node and ntfy_rst equal to the winner. A winning peer notification does not pulse ntfy_out.
- R4: The stop type is 1 (reset stop) for a node request whose node_kind bit is 1, 0 (domain stop) for a crossbar error, and peer_rst for a peer notification. It is raised to 1 if any node request with node_kind 1, or any peer notification with peer_rst 1, is present in the cycle after capture.
- R5: dmd_valid is high for exactly one cycle, the second cycle after the capture edge. dmd_rst and dmd_node carry the stop type and the node in error.
- R6: If the node in error e is not split, dmd_port_stop has bit e set, plus every port j with reach bit cfg_reach[e*N_NODES+j] set and cfg_split[j] clear.
- R7: If the node in error is split (cfg_split[e]=1), dmd_port_stop has bit e as its only set bit.
- R8: irq rises one cycle after the cycle in which every ack bit has been seen at least once since the demand. Ack bits are remembered across cycles, and acks seen in the demand cycle do not count.
- R9: Requests are ignored from capture until the stop ends. irq stays high until sw_clear is sampled high, and the arbiter then returns to idle and accepts new requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| node_req | input | N_NODES | Stop request per node concentrator |
| node_kind | input | N_NODES | Per node: 1 asks for reset stop |
| xbar_err | input | N_NODES | Crossbar error seen on a local port |
| peer_vld | input | 1 | Notification from peer arbiter |
| peer_rst | input | 1 | Peer notification asks for reset stop |
| peer_node | input | IW | Node named by peer notification |
| ntfy_out | output | 1 | Notification to peer arbiter |
| ntfy_rst | output | 1 | Stop type of outgoing notification |
| ntfy_node | output | IW | Node of outgoing notification |
| cfg_split | input | N_NODES | Split-node mask |
| cfg_reach | input | N_NODES*N_NODES | Port reachability, row e at e*N_NODES |
| dmd_valid | output | 1 | Stop demand broadcast strobe |
| dmd_rst | output | 1 | Demand stop type, 1 reset stop |
| dmd_node | output | IW | Node in error |
| dmd_port_stop | output | N_NODES | Crossbar ports to stop |
| ack | input | N_ACK | Per-resource demand acknowledge |
| irq | output | 1 | Interrupt to system controller |
| sw_clear | input | 1 | Software clears the stop |
| stat_node | output | IW | First requester node |
| stat_rst | output | 1 | Recorded stop type |
| stat_src | output | 2 | Recorded source: 0 none, 1 node, 2 crossbar, 3 peer |

## Verification
The bench runs simultaneous node and crossbar requests with mixed kinds, which shows whether priority and stop type are chosen correctly. A lone crossbar error on a split port, followed by a peer reset notification, separates the split rule from escalation. A peer-only stop on a node that reaches a split neighbour shows that split ports are filtered out and that no echo is sent. Acks are given staggered, all at once and early in the demand cycle, which shows whether the interrupt depends on the sticky collection of every acknowledge. A behavioural model is compared with all outputs on every cycle.

// File: rtl/stop_arb_pkg.sv
package stop_arb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_COLLECT   = 3'd1,
      ST_BROADCAST = 3'd2,
      ST_WAIT_ACK  = 3'd3,
      ST_INTERRUPT = 3'd4
   } arb_state_e;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_NODE = 2'd1,
      SRC_XBAR = 2'd2,
      SRC_PEER = 2'd3
   } stop_src_e;
endpackage

// File: rtl/stop_req_pick.sv
module stop_req_pick
   import stop_arb_pkg::*;
#(
   parameter int N_NODES = 8,
   localparam int IW = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
   input  logic [N_NODES-1:0] node_req,
   input  logic [N_NODES-1:0] node_kind,
   input  logic [N_NODES-1:0] xbar_err,
   input  logic               peer_vld,
   input  logic               peer_rst,
   input  logic [IW-1:0]      peer_node,
   output logic               hit,
   output logic               win_local,
   output logic [IW-1:0]      win_node,
   output logic               win_rst,
   output stop_src_e          win_src
);
   logic [IW-1:0] node_idx, xbar_idx;
   logic          node_kind_w;

   // lowest index wins: scan downward so the last write is the lowest
   always_comb begin
      node_idx    = '0;
      xbar_idx    = '0;
      node_kind_w = 1'b0;
      for (int i = N_NODES-1; i >= 0; i--) begin
         if (node_req[i]) begin
            node_idx    = IW'(i);
            node_kind_w = node_kind[i];
         end
         if (xbar_err[i]) xbar_idx = IW'(i);
      end
   end

   always_comb begin
      hit       = 1'b1;
      win_local = 1'b1;
      win_node  = '0;
      win_rst   = 1'b0;
      win_src   = SRC_NONE;
      if (|node_req) begin
         win_node = node_idx;
         win_rst  = node_kind_w;
         win_src  = SRC_NODE;
      end else if (|xbar_err) begin
         win_node = xbar_idx;
         win_src  = SRC_XBAR;
      end else if (peer_vld) begin
         win_node  = peer_node;
         win_rst   = peer_rst;
         win_src   = SRC_PEER;
         win_local = 1'b0;
      end else begin
         hit       = 1'b0;
         win_local = 1'b0;
      end
   end
endmodule

// File: rtl/stop_port_rule.sv
module stop_port_rule #(
   parameter int N_NODES = 8,
   localparam int IW = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
   input  logic [IW-1:0]              err_node,
   input  logic [N_NODES-1:0]         cfg_split,
   input  logic [N_NODES*N_NODES-1:0] cfg_reach,
   output logic [N_NODES-1:0]         stop_mask
);
   logic [N_NODES-1:0] row;
   logic               err_split;

   assign err_split = cfg_split[err_node];
   assign row       = cfg_reach[err_node*N_NODES +: N_NODES];

   for (genvar j = 0; j < N_NODES; j++) begin : g_port
      assign stop_mask[j] = (err_node == IW'(j)) |
                            (~err_split & row[j] & ~cfg_split[j]);
   end
endmodule

// File: rtl/stop_ack_track.sv
module stop_ack_track #(
   parameter int N_ACK = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [N_ACK-1:0] ack,
   output logic             all_seen
);
   logic [N_ACK-1:0] seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   seen <= '0;
      else if (clr) seen <= '0;
      else if (en)  seen <= seen | ack;
   end

   assign all_seen = en & (&(seen | ack));

   AST_SEEN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (seen == '0)) else $error("ack memory not cleared"); // R8
endmodule

// File: rtl/stop_arbiter.sv
module stop_arbiter
   import stop_arb_pkg::*;
#(
   parameter int N_NODES = 8,
   parameter int N_ACK   = 4,
   localparam int IW = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_NODES-1:0]         node_req,
   input  logic [N_NODES-1:0]         node_kind,
   input  logic [N_NODES-1:0]         xbar_err,
   input  logic                       peer_vld,
   input  logic                       peer_rst,
   input  logic [IW-1:0]              peer_node,
   output logic                       ntfy_out,
   output logic                       ntfy_rst,
   output logic [IW-1:0]              ntfy_node,
   input  logic [N_NODES-1:0]         cfg_split,
   input  logic [N_NODES*N_NODES-1:0] cfg_reach,
   output logic                       dmd_valid,
   output logic                       dmd_rst,
   output logic [IW-1:0]              dmd_node,
   output logic [N_NODES-1:0]         dmd_port_stop,
   input  logic [N_ACK-1:0]           ack,
   output logic                       irq,
   input  logic                       sw_clear,
   output logic [IW-1:0]              stat_node,
   output logic                       stat_rst,
   output logic [1:0]                 stat_src
);
   if (N_NODES < 2) begin : g_bad_nodes
      $error("stop_arbiter: N_NODES must be at least 2");
   end
   if (N_ACK < 1) begin : g_bad_ack
      $error("stop_arbiter: N_ACK must be at least 1");
   end

   arb_state_e    state;
   logic [IW-1:0] cur_node;
   logic          cur_rst;
   stop_src_e     cur_src;
   logic          hit, win_local, win_rst, escalate, all_seen;
   logic [IW-1:0] win_node;
   stop_src_e     win_src;

   stop_req_pick #(.N_NODES(N_NODES)) u_pick (
      .node_req (node_req),  .node_kind(node_kind), .xbar_err(xbar_err),
      .peer_vld (peer_vld),  .peer_rst (peer_rst),  .peer_node(peer_node),
      .hit      (hit),       .win_local(win_local), .win_node(win_node),
      .win_rst  (win_rst),   .win_src  (win_src)
   );

   stop_port_rule #(.N_NODES(N_NODES)) u_rule (
      .err_node (cur_node), .cfg_split(cfg_split), .cfg_reach(cfg_reach),
      .stop_mask(dmd_port_stop)
   );

   stop_ack_track #(.N_ACK(N_ACK)) u_ack (
      .clk(clk), .rst_n(rst_n),
      .clr(state == ST_BROADCAST), .en(state == ST_WAIT_ACK),
      .ack(ack), .all_seen(all_seen)
   );

   assign escalate = (|(node_req & node_kind)) | (peer_vld & peer_rst);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cur_node  <= '0;
         cur_rst   <= 1'b0;
         cur_src   <= SRC_NONE;
         ntfy_out  <= 1'b0;
         ntfy_rst  <= 1'b0;
         ntfy_node <= '0;
      end else begin
         ntfy_out <= 1'b0;
         unique case (state)
            ST_IDLE: if (hit) begin
               state     <= ST_COLLECT;
               cur_node  <= win_node;
               cur_rst   <= win_rst;
               cur_src   <= win_src;
               ntfy_out  <= win_local;
               ntfy_node <= win_node;
               ntfy_rst  <= win_rst;
            end
            ST_COLLECT: begin
               if (escalate) cur_rst <= 1'b1;
               state <= ST_BROADCAST;
            end
            ST_BROADCAST: state <= ST_WAIT_ACK;
            ST_WAIT_ACK:  if (all_seen) state <= ST_INTERRUPT;
            ST_INTERRUPT: if (sw_clear) state <= ST_IDLE;
            default:      state <= ST_IDLE;
         endcase
      end
   end

   assign dmd_valid = (state == ST_BROADCAST);
   assign dmd_rst   = cur_rst;
   assign dmd_node  = cur_node;
   assign irq       = (state == ST_INTERRUPT);
   assign stat_node = cur_node;
   assign stat_rst  = cur_rst;
   assign stat_src  = cur_src;

   AST_DMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      dmd_valid |=> !dmd_valid) else $error("demand longer than one cycle"); // R5
   AST_NTFY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ntfy_out |=> !ntfy_out) else $error("notify longer than one cycle"); // R3
   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !sw_clear) |=> irq) else $error("irq dropped early"); // R9
   AST_ERR_PORT_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      dmd_valid |-> dmd_port_stop[dmd_node]) else $error("errored port kept"); // R6
   AST_SPLIT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      (dmd_valid && cfg_split[dmd_node]) |-> ($countones(dmd_port_stop) == 1))
      else $error("split node stops other ports"); // R7
   AST_IRQ_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(&ack) || $past(state == ST_WAIT_ACK))
      else $error("irq without ack phase"); // R8
   AST_STATUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && state != ST_COLLECT) |=> $stable(stat_node))
      else $error("status changed while busy"); // R9
endmodule

// File: tb/stop_arbiter_tb.sv
module stop_arbiter_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 4;
   localparam int NA = 3;
   localparam int IW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] node_req = '0, node_kind = '0, xbar_err = '0, cfg_split = '0;
   logic peer_vld = 1'b0, peer_rst = 1'b0, sw_clear = 1'b0;
   logic [IW-1:0] peer_node = '0;
   logic [N*N-1:0] cfg_reach = '1;
   logic [NA-1:0] ack = '0;
   logic ntfy_out, ntfy_rst, dmd_valid, dmd_rst, irq, stat_rst;
   logic [IW-1:0] ntfy_node, dmd_node, stat_node;
   logic [N-1:0] dmd_port_stop;
   logic [1:0] stat_src;

   int n_chk = 0, n_fail = 0, cyc = 0;

   stop_arbiter #(.N_NODES(N), .N_ACK(NA)) u_dut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural model: 0 idle 1 collect 2 demand 3 wait 4 interrupt
   int m_st = 0, m_node = 0, m_rst = 0, m_src = 0, m_ntfy = 0, m_nnode = 0, m_nrst = 0;
   logic [NA-1:0] m_seen = '0;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_st = 0; m_node = 0; m_rst = 0; m_src = 0; m_ntfy = 0; m_nnode = 0; m_nrst = 0;
         m_seen = '0;
      end else begin
         m_ntfy = 0;
         case (m_st)
            0: begin
               int w; w = -1;
               for (int i = 0; i < N && w < 0; i++) if (node_req[i]) begin
                  w = i; m_node = i; m_rst = node_kind[i]; m_src = 1;
               end
               for (int i = 0; i < N && w < 0; i++) if (xbar_err[i]) begin
                  w = i; m_node = i; m_rst = 0; m_src = 2;
               end
               if (w >= 0) begin
                  m_ntfy = 1; m_nnode = m_node; m_nrst = m_rst; m_st = 1;
               end else if (peer_vld) begin
                  m_node = peer_node; m_rst = peer_rst; m_src = 3; m_st = 1;
               end
            end
            1: begin
               if ((node_req & node_kind) != 0 || (peer_vld && peer_rst)) m_rst = 1;
               m_st = 2;
            end
            2: begin m_seen = '0; m_st = 3; end
            3: begin
               m_seen = m_seen | ack;
               if (&m_seen) m_st = 4;
            end
            4: if (sw_clear) m_st = 0;
            default: m_st = 0;
         endcase
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
      end
   endtask

   function automatic int exp_mask(int e);
      int m; m = 0;
      for (int j = 0; j < N; j++)
         if (j == e || (!cfg_split[e] && cfg_reach[e*N+j] && !cfg_split[j])) m |= (1 << j);
      return m;
   endfunction

   always @(negedge clk) if (rst_n) begin
      chk("R8 irq", irq, m_st == 4);
      chk("R5 dmd_valid", dmd_valid, m_st == 2);
      chk("R3 ntfy_out", ntfy_out, m_ntfy);
      if (m_ntfy) begin
         chk("R3 ntfy_node", ntfy_node, m_nnode);
         chk("R3 ntfy_rst", ntfy_rst, m_nrst);
      end
      chk("R2 stat_src", stat_src, m_src);
      chk("R2 stat_node", stat_node, m_node);
      if (m_st >= 2) chk("R4 stat_rst", stat_rst, m_rst);
      if (m_st == 2) begin
         chk("R5 dmd_node", dmd_node, m_node);
         chk("R4 dmd_rst", dmd_rst, m_rst);
         chk(cfg_split[m_node] ? "R7 port mask" : "R6 port mask", dmd_port_stop, exp_mask(m_node));
      end
   end

   task automatic tick(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_stop(input logic [NA-1:0] a0, input logic [NA-1:0] a1);
      tick(3);            // capture, collect, demand done; now waiting
      ack = a0; tick(1);
      ack = a1; tick(1);
      ack = '0; tick(2);
      chk("R9 irq held", irq, 1);
      sw_clear = 1'b1; tick(1); sw_clear = 1'b0;
      chk("R9 back to idle", irq, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      tick(2);
      chk("R1 irq", irq, 0);
      chk("R1 dmd_valid", dmd_valid, 0);
      chk("R1 ntfy_out", ntfy_out, 0);
      chk("R1 stat_src", stat_src, 0);
      rst_n = 1'b1; tick(2);

      // nodes 1 and 2 plus crossbar 0: node 1 wins, reset kind
      node_req = 4'b0110; node_kind = 4'b0010; xbar_err = 4'b0001;
      tick(1);
      node_req = 4'b1000; node_kind = '0; xbar_err = '0;   // ignored while busy (R9)
      tick(1);
      node_req = '0;
      tick(1);
      ack = 3'b001; tick(1);
      ack = 3'b100; tick(1);
      chk("R8 no irq before last ack", irq, 0);
      ack = 3'b010; tick(1);
      ack = '0;
      chk("R8 irq after all acks", irq, 1);
      xbar_err = 4'b0001; tick(2); xbar_err = '0;      // ignored while interrupting (R9)
      chk("R9 status kept", stat_src, 1);
      sw_clear = 1'b1; tick(1); sw_clear = 1'b0; tick(2);

      // split crossbar port 3, escalated by peer reset in collect cycle
      cfg_split = 4'b1000;
      xbar_err = 4'b1000; tick(1); xbar_err = '0;
      peer_vld = 1'b1; peer_rst = 1'b1; peer_node = 2'd0; tick(1);
      peer_vld = 1'b0; peer_rst = 1'b0;
      ack = '1; tick(1);                                 // demand cycle ack does not count
      ack = 3'b011; tick(1);
      chk("R8 demand-cycle ack ignored", irq, 0);
      ack = 3'b100; tick(1); ack = '0;
      chk("R8 irq", irq, 1);
      sw_clear = 1'b1; tick(1); sw_clear = 1'b0; tick(1);

      // peer-only stop on node 2 reaching a split neighbour
      cfg_split = 4'b0010; cfg_reach = '0; cfg_reach[2*N +: N] = 4'b0111;
      peer_vld = 1'b1; peer_node = 2'd2; tick(1); peer_vld = 1'b0;
      chk("R3 no echo", ntfy_out, 0);
      finish_stop('1, '0);

      // non-split node 0 with full reach, domain stop
      cfg_split = '0; cfg_reach = '1;
      node_req = 4'b0001; tick(1); node_req = '0;
      finish_stop(3'b110, 3'b001);
      tick(3);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule